// File: doc/BRIEF.md
# Cascade Expansion Adder with Byte Shift

This block sits at the end of a partial-convolution datapath. It merges the sum computed on the local device with a partial sum arriving from an upstream device. Cascading devices this way builds convolution windows larger than one device can hold. It can also rebuild 16-bit pixel results that were split into two 8-bit halves: the upstream device computes the partial sum of the low pixel bytes. The local device computes the partial sum of the high pixel bytes. When the byte-shift control is set, the local sum is multiplied by 256 before the upstream sum is added. In the default wide mode the arithmetic is 32-bit two's complement, so the recombination is exact.

A narrow mode serves chains that carry only 16 bits between devices. In this mode only the low 16 bits of each operand are used, each sign-extended. The result is returned as a sign-extended 16-bit value. If the exact sum cannot be represented in 16 bits, a sticky flag is set. A small state machine records whether the held result is narrow or wide. Its states are S_IDLE (no result since reset), S_WIDE and S_NARROW. On every accepted sample, each state moves to S_WIDE or S_NARROW, following the mode of that sample. With no sample, the state stays where it is.

Top module: `casc_add`

## Requirements
- R1: While reset is asserted and just after it is released, out_valid=0, out_sum=0, out_narrow=0 and ovf_sticky=0.
- R2: A sample is accepted on a rising edge where in_valid=1. Its result appears on out_sum with out_valid=1 after exactly that one edge. out_valid is 0 after any edge where in_valid=0.
- R3: In wide mode (narrow=0) with byte_shift=0, out_sum = local_sum + exp_sum modulo 2^32, with both operands in two's complement.
- R4: In wide mode with byte_shift=1, out_sum = local_sum*256 + exp_sum modulo 2^32. The local operand is the one scaled.
- R5: In narrow mode (narrow=1), only bits 15:0 of local_sum and of exp_sum are used, each sign-extended. Bits 31:16 of both inputs have no effect.
- R6: In narrow mode, the exact sum is formed: the sign-extended local value (times 256 when byte_shift=1) plus the sign-extended upstream value. out_sum is bits 15:0 of that exact sum, sign-extended to 32 bits.
- R7: ovf_sticky goes to 1 on the edge that accepts a narrow sample whose exact sum lies outside [-32768, 32767]. It stays 1 until reset. Wide samples never set it.
- R8: While in_valid=0, out_sum, out_narrow and ovf_sticky keep their values, whatever the other inputs do.
- R9: out_narrow is 1 exactly when the held result came from a narrow sample (state S_NARROW). It is 0 in S_IDLE and S_WIDE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe for local_sum and exp_sum |
| narrow | input | 1 | 1 selects the 16-bit reduced-precision mode |
| byte_shift | input | 1 | 1 multiplies the local sum by 256 before the add |
| local_sum | input | 32 | Local partial sum, two's complement |
| exp_sum | input | 32 | Upstream expansion partial sum, two's complement |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_sum | output | 32 | Combined sum, held between samples |
| out_narrow | output | 1 | Held result came from narrow mode |
| ovf_sticky | output | 1 | Sticky 16-bit overflow flag |

## Verification
The shift-and-add result and the overflow detection can fall in the same cycle. This happens when a narrow sample with byte_shift set pushes the scaled local value past 16 bits. The sum and the flag must then both be right on the same edge: the wrapped 16-bit sum and the newly set sticky bit. The bench provokes this by sweeping boundary operands (±32767, -32768, ±1, and values with junk in the upper bits) across both shift settings and both modes. It judges each edge against sums that it computes in 64-bit integers. The wide sweep runs first, to show that no wide sample sets the flag before any narrow one arrives.

// File: rtl/casc_pkg.sv
package casc_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WIDE   = 2'd1,
        S_NARROW = 2'd2
    } res_state_t;

endpackage

// File: rtl/casc_operand.sv
// Operand preparation: optional narrowing with sign extension, optional
// byte scaling (left shift). The shift capability exists only when
// HAS_SHIFT is set.
module casc_operand #(
    parameter int ACC_W     = 32,
    parameter int NARROW_W  = 16,
    parameter int SHIFT     = 8,
    parameter bit HAS_SHIFT = 1'b1
) (
    input  logic [ACC_W-1:0] raw,
    input  logic             narrow,
    input  logic             scale,
    output logic [ACC_W-1:0] opnd
);
    localparam int EXT_W = ACC_W - NARROW_W;

    logic [ACC_W-1:0] sized;

    always_comb begin
        if (narrow)
            sized = {{EXT_W{raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
        else
            sized = raw;
    end

    generate
        if (HAS_SHIFT) begin : g_shift
            always_comb begin
                opnd = scale ? (sized << SHIFT) : sized;
            end
        end else begin : g_plain
            logic unused_scale;
            assign unused_scale = scale;
            assign opnd = sized;
        end
    endgenerate
endmodule

// File: rtl/casc_sum.sv
// Two's complement adder with narrow-mode wrap and overflow detection.
module casc_sum #(
    parameter int ACC_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] b,
    input  logic             narrow,
    output logic [ACC_W-1:0] result,
    output logic             ovf
);
    localparam int EXT_W = ACC_W - NARROW_W;
    localparam int TOP_W = ACC_W - NARROW_W + 1;

    logic [ACC_W-1:0] full;
    logic [TOP_W-1:0] upper;

    always_comb begin
        full  = a + b;
        upper = full[ACC_W-1:NARROW_W-1];
        if (narrow) begin
            result = {{EXT_W{full[NARROW_W-1]}}, full[NARROW_W-1:0]};
            ovf    = !((&upper) || !(|upper));
        end else begin
            result = full;
            ovf    = 1'b0;
        end
    end
endmodule

// File: rtl/casc_ctrl.sv
// Result-mode state machine: tracks the precision of the held result.
module casc_ctrl
    import casc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic narrow,
    output logic out_narrow,
    output logic load
);
    res_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_WIDE, S_NARROW: begin
                if (in_valid) state_nx = narrow ? S_NARROW : S_WIDE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        load       = in_valid;
        out_narrow = 1'b0;
        unique case (state)
            S_IDLE:   out_narrow = 1'b0;
            S_WIDE:   out_narrow = 1'b0;
            S_NARROW: out_narrow = 1'b1;
            default:  out_narrow = 1'b0;
        endcase
    end
endmodule

// File: rtl/casc_add.sv
module casc_add #(
    parameter int ACC_W    = 32,
    parameter int NARROW_W = 16,
    parameter int SHIFT    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             narrow,
    input  logic             byte_shift,
    input  logic [ACC_W-1:0] local_sum,
    input  logic [ACC_W-1:0] exp_sum,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_sum,
    output logic             out_narrow,
    output logic             ovf_sticky
);
    logic [ACC_W-1:0] op_loc, op_exp, sum_c;
    logic             ovf_c, load;

    casc_operand #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .SHIFT(SHIFT),
                   .HAS_SHIFT(1'b1)) u_op_loc (
        .raw(local_sum), .narrow(narrow), .scale(byte_shift), .opnd(op_loc));

    casc_operand #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .SHIFT(SHIFT),
                   .HAS_SHIFT(1'b0)) u_op_exp (
        .raw(exp_sum), .narrow(narrow), .scale(1'b0), .opnd(op_exp));

    casc_sum #(.ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_sum (
        .a(op_loc), .b(op_exp), .narrow(narrow), .result(sum_c), .ovf(ovf_c));

    casc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .narrow(narrow),
        .out_narrow(out_narrow), .load(load));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sum    <= '0;
            ovf_sticky <= 1'b0;
        end else begin
            out_valid <= load;
            if (load) begin
                out_sum <= sum_c;
                if (ovf_c) ovf_sticky <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/casc_add_chk.sv
module casc_add_chk #(
    parameter int ACC_W    = 32,
    parameter int NARROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             narrow,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_sum,
    input logic             out_narrow,
    input logic             ovf_sticky
);
    localparam int TOP_W = ACC_W - NARROW_W + 1;

    logic [TOP_W-1:0] top_bits;
    assign top_bits = out_sum[ACC_W-1:NARROW_W-1];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sum) && $stable(out_narrow)); // R8
    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_narrow |-> ((&top_bits) || !(|top_bits))); // R6
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky); // R7
    AST_OVF_NARROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !narrow && !ovf_sticky) |=> !ovf_sticky); // R7
    AST_MODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_narrow == $past(narrow))); // R9
endmodule

bind casc_add casc_add_chk #(.ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .narrow(narrow),
    .out_valid(out_valid), .out_sum(out_sum), .out_narrow(out_narrow),
    .ovf_sticky(ovf_sticky));

// File: tb/tb_casc_add.sv
module tb_casc_add;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        narrow = 1'b0;
    logic        byte_shift = 1'b0;
    logic [31:0] local_sum = '0;
    logic [31:0] exp_sum = '0;
    logic        out_valid, out_narrow, ovf_sticky;
    logic [31:0] out_sum;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit exp_sticky = 1'b0;

    always #4 clk = ~clk;

    casc_add dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .narrow(narrow),
        .byte_shift(byte_shift), .local_sum(local_sum), .exp_sum(exp_sum),
        .out_valid(out_valid), .out_sum(out_sum), .out_narrow(out_narrow),
        .ovf_sticky(ovf_sticky));

    function automatic logic [31:0] pick(input int i);
        case (i)
            0: pick = 32'h0000_0000;
            1: pick = 32'h0000_0001;
            2: pick = 32'hFFFF_FFFF;
            3: pick = 32'h0000_7FFF;
            4: pick = 32'hFFFF_8000;
            5: pick = 32'h1234_0080;
            6: pick = 32'h7FFF_FFFF;
            default: pick = 32'h8000_0000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run_one(input logic [31:0] l, input logic [31:0] e,
                           input bit sh, input bit nr);
        longint a, b, full;
        logic [31:0] expv;
        bit ovf;
        @(negedge clk);
        in_valid = 1'b1; local_sum = l; exp_sum = e;
        byte_shift = sh; narrow = nr;
        if (nr) begin
            a = longint'($signed(l[15:0]));
            b = longint'($signed(e[15:0]));
        end else begin
            a = longint'($signed(l));
            b = longint'($signed(e));
        end
        full = (sh ? a * 256 : a) + b;
        if (nr) begin
            expv = {{16{full[15]}}, full[15:0]};
            ovf = (full > 32767) || (full < -32768);
        end else begin
            expv = full[31:0];
            ovf = 1'b0;
        end
        if (ovf) exp_sticky = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (nr)
            chk(out_sum == expv, sh ? "R6 narrow shifted sum (R5)" : "R6 narrow sum (R5)",
                out_sum, expv);
        else
            chk(out_sum == expv, sh ? "R4 wide shifted sum" : "R3 wide sum",
                out_sum, expv);
        chk(out_valid == 1'b1, "R2 out_valid", {31'b0, out_valid}, 32'd1);
        chk(out_narrow == nr, "R9 out_narrow", {31'b0, out_narrow}, {31'b0, nr});
        chk(ovf_sticky == exp_sticky, "R7 ovf_sticky", {31'b0, ovf_sticky},
            {31'b0, exp_sticky});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_sum == 0 && out_narrow == 0 && ovf_sticky == 0,
            "R1 in reset", out_sum, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && out_sum == 0 && out_narrow == 0 && ovf_sticky == 0,
            "R1 after release", out_sum, 32'd0);

        // Wide sweep first: the sticky flag must stay clear (R7).
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_one(pick(i), pick(j), s[0], 1'b0);
        chk(ovf_sticky == 1'b0, "R7 wide never sets flag", {31'b0, ovf_sticky}, 32'd0);

        // Upper bits ignored in narrow mode (R5).
        run_one(32'hABCD_0005, 32'h5555_0003, 1'b0, 1'b1);
        run_one(32'h0000_0005, 32'h0000_0003, 1'b0, 1'b1);

        // Narrow sweep: combined shift, wrap and overflow.
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_one(pick(i), pick(j), s[0], 1'b1);

        // Hold behaviour (R8): inputs change, in_valid low.
        held = out_sum;
        @(negedge clk);
        local_sum = 32'h0F0F_0F0F; exp_sum = 32'h7000_0000;
        narrow = 1'b0; byte_shift = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_sum == held, "R8 sum held", out_sum, held);
        chk(out_narrow == 1'b1, "R8 mode held", {31'b0, out_narrow}, 32'd1);
        chk(out_valid == 1'b0, "R2 valid low when idle", {31'b0, out_valid}, 32'd0);
        chk(ovf_sticky == exp_sticky, "R7 sticky held", {31'b0, ovf_sticky},
            {31'b0, exp_sticky});

        // Wide sample after narrow: flag stays, mode switches (R7, R9).
        run_one(32'd10, 32'd20, 1'b0, 1'b0);

        // Reset clears everything (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_sticky = 1'b0;
        @(negedge clk);
        chk(out_valid == 0 && out_sum == 0 && out_narrow == 0 && ovf_sticky == 0,
            "R1 second reset", {31'b0, ovf_sticky}, 32'd0);

        // Narrow overflow exactly at the boundary (R7).
        run_one(32'h0000_7FFF, 32'h0000_0000, 1'b0, 1'b1);
        run_one(32'h0000_7FFF, 32'h0000_0001, 1'b0, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule